// File: doc/BRIEF.md
# Call-Graph Control-Flow Checker

This block watches a processor's program execution one function at a time. The processor reports each function call and each function return as an event. An event carries a strobe, a call/return flag and the index of the function being entered. Before monitoring begins, software loads a register table of permitted caller-to-callee edges. The edges come from a call graph worked out offline. Once the table is loaded, a configuration-done input is raised.

From then on, the checker behaves as a state machine with one state per function. It starts in the entry function, index 0. A call is accepted only along a loaded edge. A return is accepted only back to the function that made the matching call, and a 16-entry return stack tracks that caller. This is how functions that have more than one caller are told apart.

Each event receives a pass/fail verdict one clock after its strobe, and one event can be taken on every clock. The first failed event raises a sticky violation output, which can halt or alert the processor. It also freezes the current function and the stack depth so that software can inspect the fault context.

Top module: `cfc_monitor`

## Requirements
- R1: After reset `violation_o` is 0, `verdict_valid_o` is 0, `cur_func_o` is 0 (the entry function) and `depth_o` is 0.
- R2: While `cfg_done_i` is 0, events are ignored. No verdict is produced, and `cur_func_o` and `depth_o` do not change.
- R3: Table bit `cfg_row_i[j]` written for row `cfg_idx_i = i` permits a call from function i to function j. Such a call event (`ev_call_i` = 1, `ev_func_i` = j) made while in state i gives `verdict_ok_o` = 1 on the clock after the strobe. On that same clock `cur_func_o` becomes j and `depth_o` rises by 1.
- R4: A call event whose edge is not in the table gives `verdict_ok_o` = 0 and raises `violation_o` on the clock after the strobe.
- R5: A return event (`ev_call_i` = 0) is legal only when the stack is non-empty and `ev_func_i` equals the caller recorded by the matching call. A legal return gives `verdict_ok_o` = 1, sets `cur_func_o` to that caller and lowers `depth_o` by 1. A return to any other function is a violation.
- R6: A return event while `depth_o` is 0 is a violation.
- R7: A call event while `depth_o` equals 16 is a violation, even along a permitted edge, and `depth_o` stays at 16.
- R8: `violation_o` stays high until `clr_i` is asserted. While it is high, events still receive verdicts, but `cur_func_o` and `depth_o` stay frozen.
- R9: `clr_i` lowers `violation_o` on the next clock. If a failing event is judged on the same clock as the clear, the violation stays high.
- R10: Table writes made while `cfg_done_i` is 1 are ignored.
- R11: Events on consecutive clocks each receive their own verdict on the clock after their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table row write strobe |
| cfg_idx_i | input | 3 | Caller function index of the row being written |
| cfg_row_i | input | 8 | Permitted callee bitmap for that caller |
| cfg_done_i | input | 1 | Table loaded; enables checking and locks the table |
| ev_valid_i | input | 1 | Event strobe |
| ev_call_i | input | 1 | 1 = call, 0 = return |
| ev_func_i | input | 3 | Function being entered (callee, or caller on return) |
| clr_i | input | 1 | Clears the sticky violation |
| verdict_valid_o | output | 1 | A verdict is present this cycle |
| verdict_ok_o | output | 1 | Verdict: 1 legal, 0 illegal |
| violation_o | output | 1 | Sticky violation flag |
| cur_func_o | output | 3 | Current function state |
| depth_o | output | 5 | Return stack depth |

## Verification
A violation clear and a newly failing event can land on the same clock edge. The rule is that the new failure wins. The bench provokes this by asserting `clr_i` in the same cycle as an overflowing call, made while the flag is already set. It then expects `violation_o` still to be high a clock later, and `depth_o` to be unchanged. A clear issued alone must drop the flag, after which a legal return must advance the state again. The legal and illegal return cases also cover a function reached through two different callers.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned CFC_N_FUNC      = 8;
  localparam int unsigned CFC_STACK_DEPTH = 16;

  typedef enum logic {
    EV_RET  = 1'b0,
    EV_CALL = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/cfc_adj_table.sv
module cfc_adj_table #(
  parameter int unsigned N_FUNC = 8,
  localparam int unsigned FW = $clog2(N_FUNC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [FW-1:0]     widx_i,
  input  logic [N_FUNC-1:0] wrow_i,
  input  logic [FW-1:0]     cur_i,
  input  logic [FW-1:0]     tgt_i,
  output logic              call_edge_o,
  output logic              ret_edge_o
);
  logic [N_FUNC-1:0] tbl_q [N_FUNC];

  for (genvar r = 0; r < N_FUNC; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl_q[r] <= '0;
      else if (we_i && !lock_i && widx_i == FW'(r)) tbl_q[r] <= wrow_i;
    end
  end

  assign call_edge_o = tbl_q[cur_i][tgt_i];
  assign ret_edge_o  = tbl_q[tgt_i][cur_i];
endmodule

// File: rtl/cfc_ret_stack.sv
module cfc_ret_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 3,
  localparam int unsigned DW  = $clog2(DEPTH + 1),
  localparam int unsigned SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [DW-1:0] depth_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [DW-1:0] depth_q;
  logic [SPW-1:0] wr_idx, top_idx;

  assign wr_idx  = SPW'(depth_q);
  assign top_idx = SPW'(depth_q - DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[wr_idx] <= din_i;
      depth_q       <= depth_q + DW'(1);
    end else if (pop_i) begin
      depth_q <= depth_q - DW'(1);
    end
  end

  assign top_o   = mem_q[top_idx];
  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));
  assign depth_o = depth_q;
endmodule

// File: rtl/cfc_judge.sv
module cfc_judge #(
  parameter int unsigned W = 3
) (
  input  logic         is_call_i,
  input  logic [W-1:0] tgt_i,
  input  logic         call_edge_i,
  input  logic         ret_edge_i,
  input  logic         full_i,
  input  logic         empty_i,
  input  logic [W-1:0] top_i,
  output logic         ok_o
);
  always_comb begin
    if (is_call_i) ok_o = call_edge_i && !full_i;
    else           ok_o = !empty_i && (top_i == tgt_i) && ret_edge_i;
  end
endmodule

// File: rtl/cfc_monitor.sv
module cfc_monitor #(
  parameter int unsigned N_FUNC      = cfc_pkg::CFC_N_FUNC,
  parameter int unsigned STACK_DEPTH = cfc_pkg::CFC_STACK_DEPTH,
  localparam int unsigned FW = $clog2(N_FUNC),
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [FW-1:0]     cfg_idx_i,
  input  logic [N_FUNC-1:0] cfg_row_i,
  input  logic              cfg_done_i,
  input  logic              ev_valid_i,
  input  logic              ev_call_i,
  input  logic [FW-1:0]     ev_func_i,
  input  logic              clr_i,
  output logic              verdict_valid_o,
  output logic              verdict_ok_o,
  output logic              violation_o,
  output logic [FW-1:0]     cur_func_o,
  output logic [DW-1:0]     depth_o
);
  import cfc_pkg::*;

  logic [FW-1:0] cur_q, top;
  logic call_edge, ret_edge, full, empty, ok, accept, advance, viol_q;
  logic vld_q, ok_q;

  cfc_adj_table #(.N_FUNC(N_FUNC)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .lock_i(cfg_done_i),
    .widx_i(cfg_idx_i), .wrow_i(cfg_row_i),
    .cur_i(cur_q), .tgt_i(ev_func_i),
    .call_edge_o(call_edge), .ret_edge_o(ret_edge)
  );

  assign accept  = ev_valid_i && cfg_done_i;
  assign advance = accept && ok && !viol_q;

  cfc_ret_stack #(.DEPTH(STACK_DEPTH), .W(FW)) u_stk (
    .clk_i, .rst_ni,
    .push_i(advance && ev_call_i == EV_CALL),
    .pop_i(advance && ev_call_i == EV_RET),
    .din_i(cur_q), .top_o(top),
    .empty_o(empty), .full_o(full), .depth_o(depth_o)
  );

  cfc_judge #(.W(FW)) u_judge (
    .is_call_i(ev_call_i == EV_CALL), .tgt_i(ev_func_i),
    .call_edge_i(call_edge), .ret_edge_i(ret_edge),
    .full_i(full), .empty_i(empty), .top_i(top),
    .ok_o(ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      viol_q <= 1'b0;
      vld_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      vld_q  <= accept;
      ok_q   <= accept && ok;
      // a fresh failure outranks a clear in the same cycle
      viol_q <= (viol_q && !clr_i) || (accept && !ok);
      if (advance) cur_q <= ev_func_i;
    end
  end

  assign verdict_valid_o = vld_q;
  assign verdict_ok_o    = ok_q;
  assign violation_o     = viol_q;
  assign cur_func_o      = cur_q;
endmodule

// File: rtl/cfc_monitor_chk.sv
module cfc_monitor_chk #(
  parameter int unsigned N_FUNC      = 8,
  parameter int unsigned STACK_DEPTH = 16,
  localparam int unsigned FW = $clog2(N_FUNC),
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_done_i,
  input logic          ev_valid_i,
  input logic          ev_call_i,
  input logic          clr_i,
  input logic          verdict_valid_o,
  input logic          verdict_ok_o,
  input logic          violation_o,
  input logic [FW-1:0] cur_func_o,
  input logic [DW-1:0] depth_o
);
  // R2
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && !cfg_done_i) |=> !verdict_valid_o);

  // R4
  bad_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_valid_o && !verdict_ok_o) |-> violation_o);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (violation_o && !clr_i) |=> violation_o);

  // R8
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> ($stable(cur_func_o) && $stable(depth_o)));

  // R3
  push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && cfg_done_i && ev_call_i && !violation_o) |=>
      (!verdict_ok_o || depth_o == $past(depth_o) + DW'(1)));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(STACK_DEPTH));

  // R11
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && cfg_done_i) |=> verdict_valid_o);
endmodule

bind cfc_monitor cfc_monitor_chk #(.N_FUNC(N_FUNC), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_done_i(cfg_done_i),
  .ev_valid_i(ev_valid_i), .ev_call_i(ev_call_i), .clr_i(clr_i),
  .verdict_valid_o(verdict_valid_o), .verdict_ok_o(verdict_ok_o),
  .violation_o(violation_o), .cur_func_o(cur_func_o), .depth_o(depth_o)
);

// File: tb/cfc_monitor_test.sv
module cfc_monitor_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, cfg_done = 0, ev_valid = 0, ev_call = 0, clr = 0;
  logic [2:0] cfg_idx = 0, ev_func = 0;
  logic [7:0] cfg_row = 0;
  logic vv, vok, viol;
  logic [2:0] cur;
  logic [4:0] depth;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cfc_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_row_i(cfg_row), .cfg_done_i(cfg_done), .ev_valid_i(ev_valid),
    .ev_call_i(ev_call), .ev_func_i(ev_func), .clr_i(clr),
    .verdict_valid_o(vv), .verdict_ok_o(vok), .violation_o(viol),
    .cur_func_o(cur), .depth_o(depth)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one event for one clock, then check outputs after the edge
  task automatic ev(string req, bit call, int f, bit eok, int ecur, int edep, bit eviol,
                    bit with_clr = 0);
    @(negedge clk);
    ev_valid = 1; ev_call = call; ev_func = 3'(f); clr = with_clr;
    @(posedge clk); #1;
    check({req, " vv"}, vv, 1);
    check({req, " ok"}, vok, eok);
    check({req, " cur"}, cur, ecur);
    check({req, " depth"}, depth, edep);
    check({req, " viol"}, viol, eviol);
  endtask

  task automatic idle;
    @(negedge clk); ev_valid = 0; clr = 0; cfg_we = 0;
  endtask

  task automatic do_clear(string req);
    @(negedge clk); ev_valid = 0; clr = 1;
    @(posedge clk); #1;
    check({req, " clear"}, viol, 0);
    idle();
  endtask

  task automatic load_row(int idx, logic [7:0] row);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_row = row;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset;
    check("R1 viol", viol, 0);
    check("R1 vv", vv, 0);
    check("R1 cur", cur, 0);
    check("R1 depth", depth, 0);
  endtask

  task automatic t_gate;
    @(negedge clk); ev_valid = 1; ev_call = 1; ev_func = 3'd1;
    @(posedge clk); #1;
    check("R2 vv", vv, 0);
    check("R2 cur", cur, 0);
    check("R2 depth", depth, 0);
    idle();
  endtask

  // graph: 0->1,0->2,0->5, 1->3, 2->3, 3->4, 5->5
  task automatic t_load;
    load_row(0, 8'b0010_0110);
    load_row(1, 8'b0000_1000);
    load_row(2, 8'b0000_1000);
    load_row(3, 8'b0001_0000);
    load_row(5, 8'b0010_0000);
    @(negedge clk); cfg_done = 1;
  endtask

  task automatic t_chain;  // back-to-back, no idle between
    ev("R3 R11 call 0->1", 1, 1, 1, 1, 1, 0);
    ev("R3 R11 call 1->3", 1, 3, 1, 3, 2, 0);
    ev("R3 R11 call 3->4", 1, 4, 1, 4, 3, 0);
    ev("R5 R11 ret 4->3", 0, 3, 1, 3, 2, 0);
    ev("R5 R11 ret 3->1", 0, 1, 1, 1, 1, 0);
    ev("R5 R11 ret 1->0", 0, 0, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_two_callers;
    ev("R3 call 0->2", 1, 2, 1, 2, 1, 0);
    ev("R3 call 2->3", 1, 3, 1, 3, 2, 0);
    ev("R5 ret to wrong caller", 0, 1, 0, 3, 2, 1);
    ev("R8 frozen legal ret", 0, 2, 1, 3, 2, 1);
    idle();
    do_clear("R9");
    ev("R5 ret 3->2", 0, 2, 1, 2, 1, 0);
    ev("R5 ret 2->0", 0, 0, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_empty_ret;
    ev("R6 ret empty", 0, 0, 0, 0, 0, 1);
    idle();
    do_clear("R6");
  endtask

  task automatic t_undefined;
    ev("R4 call 0->4", 1, 4, 0, 0, 0, 1);
    idle();
    do_clear("R4");
  endtask

  task automatic t_overflow;
    ev("R7 call 0->5", 1, 5, 1, 5, 1, 0);
    for (int i = 2; i <= 16; i++) ev("R7 fill", 1, 5, 1, 5, i, 0);
    ev("R7 overflow", 1, 5, 0, 5, 16, 1);
    ev("R9 clear vs fail", 1, 5, 0, 5, 16, 1, 1);
    idle();
    @(posedge clk); #1;
    check("R9 still set", viol, 1);
    do_clear("R9");
    for (int i = 15; i >= 1; i--) ev("R5 unwind", 0, 5, 1, 5, i, 0);
    ev("R5 unwind last", 0, 0, 1, 0, 0, 0);
    idle();
  endtask

  task automatic t_lock;
    load_row(0, 8'b1000_0000);
    ev("R10 locked write", 1, 7, 0, 0, 0, 1);
    idle();
    do_clear("R10");
    ev("R10 old row kept", 1, 1, 1, 1, 1, 0);
    ev("R10 back", 0, 0, 1, 0, 0, 0);
    idle();
  endtask

  initial begin
    #(3*CLK_P + 2);
    t_reset();
    @(negedge clk); rst_ni = 1;
    t_gate();
    t_load();
    t_chain();
    t_two_callers();
    t_empty_ret();
    t_undefined();
    t_overflow();
    t_lock();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000*CLK_P);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule